// File: doc/BRIEF.md
# Two-Step Pin Pull Configuration Unit

This block holds the pull resistor setting for a bank of pins (54 by default) and drives one pull-up enable and one pull-down enable for each of them. Software never writes a pin's pull setting directly. It first loads a 2-bit pull code into a single mode register. It then writes a strobe mask to one of the strobe registers. Every pin whose strobe bit is 1 copies the code that the mode register holds at that moment. A single strobe write can therefore reconfigure any number of pins to the same setting. Pins whose strobe bit is 0 keep their setting.

The block sits on a simple 32-bit register bus. A write is accepted on any clock edge where `bus_wr_en` is high. A read is requested with `bus_rd_en`, and the read data comes back one cycle later with `bus_rvalid`. The pin enables come straight from per-pin state registers, so they change on the same edge that accepts the strobe write.

Top module: `pull_cfg_unit`

## Requirements
- R1: The mode register sits at byte offset 0x94 and stores `bus_wdata[1:0]`. A read of 0x94 returns the stored code in bits [1:0], with all higher bits 0.
- R2: A strobe write gives every pin whose strobe bit is 1 the current code: 00 turns both pulls off, 01 turns on only the pull-down, 10 turns on only the pull-up.
- R3: A pin whose strobe bit is 0, or that receives no strobe write, keeps its pull outputs unchanged.
- R4: Code 11 is reserved. A strobe write while the mode register holds 11 changes no pin.
- R5: `pull_up_en[i]` and `pull_dn_en[i]` are never 1 together for any pin i.
- R6: After reset every pin has both enables at 0 and the mode register reads 00.
- R7: Read data arrives in the cycle after `bus_rd_en`, with `bus_rvalid` high. Reads of the strobe registers and of unmapped offsets return 0.
- R8: Bit i of a write to offset 0x98 strobes pin i (i = 0..31). Bit i of a write to offset 0x9C strobes pin 32+i. Bits of 0x9C above pin 53 (bits 22..31) are ignored.
- R9: One strobe write with many bits set configures all of the selected pins on the same edge.
- R10: A strobe write uses the code held in the mode register when the strobe write is accepted, so a mode write accepted one cycle earlier already applies to it. Writes to unmapped offsets change neither the mode nor any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write request, accepted on the rising edge |
| bus_rd_en | input | 1 | Read request, accepted on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pull_up_en | output | 54 | Per-pin pull-up enable |
| pull_dn_en | output | 54 | Per-pin pull-down enable |

## Verification
The bench targets the ordering hazard: a mode write followed directly by a strobe write. A design that sampled the mode one cycle late would apply the previous code to the strobed pins. It strobes with the reserved code set, where a design without the guard would load 11 and drive both enables at once. It writes the upper strobe register with bits set above pin 53, and sets bits 0 and 21 of that register so that an off-by-one in the pin-to-bit mapping shows up on pins 32 and 53. It also checks that strobe registers read back 0 and that a write to an unmapped offset leaves the mode and all pins untouched.

// File: rtl/pull_cfg_pkg.sv
package pull_cfg_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UP   = 2'b10,
        PULL_RSVD = 2'b11
    } pull_code_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pull_drive_t;

    localparam int unsigned MODE_OFFSET   = 32'h94;
    localparam int unsigned STROBE_OFFSET = 32'h98;
    localparam int unsigned BANK_STRIDE   = 4;

    function automatic logic code_is_legal(input pull_code_e c);
        return c != PULL_RSVD;
    endfunction

    function automatic pull_drive_t code_to_drive(input pull_code_e c);
        pull_drive_t d;
        d.up = (c == PULL_UP);
        d.dn = (c == PULL_DOWN);
        return d;
    endfunction

endpackage

// File: rtl/pull_cfg_regif.sv
module pull_cfg_regif
    import pull_cfg_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 54,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned MODE_OFS   = MODE_OFFSET,
    parameter int unsigned STB_OFS    = STROBE_OFFSET,
    parameter int unsigned STB_STRIDE = BANK_STRIDE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid,
    output pull_code_e          mode,
    output logic [NUM_PINS-1:0] strobe
);

    localparam int unsigned BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

    logic [BANKS-1:0] bank_hit;
    logic             mode_hit_wr;
    logic             mode_hit_rd;

    assign mode_hit_wr = wr_en && (addr == ADDR_W'(MODE_OFS));
    assign mode_hit_rd = rd_en && (addr == ADDR_W'(MODE_OFS));

    // one decoder per strobe bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_hit[b] = wr_en && (addr == ADDR_W'(STB_OFS + b * STB_STRIDE));
    end

    // each pin takes its bit from the bank that covers it
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_stb
        assign strobe[p] = bank_hit[p / DATA_W] & wdata[p % DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PULL_NONE;
        end else if (mode_hit_wr) begin
            mode <= pull_code_e'(wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= mode_hit_rd ? DATA_W'(mode) : '0;
        end
    end

endmodule

// File: rtl/pull_cfg_pin.sv
module pull_cfg_pin
    import pull_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  pull_code_e code,
    output pull_code_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PULL_NONE;
        end else if (strobe && code_is_legal(code)) begin
            state <= code;
        end
    end

endmodule

// File: rtl/pull_cfg_drive.sv
module pull_cfg_drive
    import pull_cfg_pkg::*;
(
    input  pull_code_e state,
    output logic       up_en,
    output logic       dn_en
);

    pull_drive_t drv;

    always_comb begin
        drv   = code_to_drive(state);
        up_en = drv.up;
        dn_en = drv.dn;
    end

endmodule

// File: rtl/pull_cfg_unit.sv
module pull_cfg_unit
    import pull_cfg_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_PINS-1:0] pull_up_en,
    output logic [NUM_PINS-1:0] pull_dn_en
);

    pull_code_e          mode_q;
    logic [NUM_PINS-1:0] strobe;

    pull_cfg_regif #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) regif_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .mode   (mode_q),
        .strobe (strobe)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pull_code_e state;

        pull_cfg_pin pin_i (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe[p]),
            .code   (mode_q),
            .state  (state)
        );

        pull_cfg_drive drive_i (
            .state (state),
            .up_en (pull_up_en[p]),
            .dn_en (pull_dn_en[p])
        );
    end

endmodule

// File: rtl/pull_cfg_chk.sv
module pull_cfg_chk #(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_rvalid,
    input logic [NUM_PINS-1:0] pull_up_en,
    input logic [NUM_PINS-1:0] pull_dn_en,
    input logic [1:0]          mode_q
);

    AST_NEVER_BOTH_PULLS: assert property (@(posedge clk) disable iff (rst)
        (pull_up_en & pull_dn_en) == '0); // R5

    AST_RESET_CLEARS_PULLS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pull_up_en == '0 && pull_dn_en == '0 && mode_q == 2'b00)); // R6

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr_en) |-> ($stable(pull_up_en) && $stable(pull_dn_en))); // R3

    AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == 2'b11) |-> ($stable(pull_up_en) && $stable(pull_dn_en))); // R4

    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rd_en) && ($past(bus_addr) == ADDR_W'(8'h98) || $past(bus_addr) == ADDR_W'(8'h9C)))
        |-> (bus_rvalid && bus_rdata == '0)); // R7

    AST_MODE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> (bus_rdata[DATA_W-1:2] == '0)); // R1

endmodule

bind pull_cfg_unit pull_cfg_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .mode_q     (mode_q)
);

// File: tb/pull_cfg_unit_tb_top.sv
module pull_cfg_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 54;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NP-1:0] pull_up_en;
    logic [NP-1:0] pull_dn_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] mdl_mode = 2'b00;
    logic [1:0] mdl_pin [NP];

    typedef struct {
        logic [31:0] exp;
        string       req;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pull_cfg_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_wr_en  (bus_wr_en),
        .bus_rd_en  (bus_rd_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en)
    );

    // model: apply strobes with the mode held before this write
    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h94) begin
            mdl_mode = d[1:0];
        end else if (a == 8'h98 || a == 8'h9C) begin
            for (int p = 0; p < NP; p++) begin
                logic hit;
                hit = (p < 32) ? (a == 8'h98 && d[p]) : (a == 8'h9C && d[p-32]);
                if (hit && mdl_mode != 2'b11) mdl_pin[p] = mdl_mode;
            end
        end
    endtask

    // driver: starts just after a falling edge, returns after the next one
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_item_t it;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        bus_rd_en = 1'b1;
        bus_addr  = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic check_pins(input string req);
        logic [NP-1:0] eu;
        logic [NP-1:0] ed;
        for (int p = 0; p < NP; p++) begin
            eu[p] = (mdl_pin[p] == 2'b10);
            ed[p] = (mdl_pin[p] == 2'b01);
        end
        checks++;
        if (pull_up_en !== eu || pull_dn_en !== ed) begin
            failures++;
            $display("FAIL %s pins: up=%h dn=%h expected up=%h dn=%h",
                     req, pull_up_en, pull_dn_en, eu, ed);
        end
    endtask

    // monitor: pop one expected item per returned read
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R7 unexpected read data: actual=%h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s read: actual=%h expected=%h", it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) mdl_pin[p] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6 reset state
        check_pins("R6");
        bus_read(8'h94, 32'h0, "R6");

        // R1 mode store and readback
        bus_write(8'h94, 32'hFFFF_FFF6);
        bus_read(8'h94, 32'h2, "R1");

        // R2 R9 pull-up on several pins with one write
        bus_write(8'h98, 32'h0000_00F0);
        check_pins("R2");
        bus_write(8'h98, 32'hFFFF_0000);
        check_pins("R9");

        // R8 upper bank mapping, bits above pin 53 ignored
        bus_write(8'h94, 32'h1);
        bus_write(8'h9C, 32'hFFC0_0001);
        check_pins("R8");
        bus_write(8'h9C, 32'h0020_0000);
        check_pins("R8");

        // R2 code 00 clears, R3 others kept
        bus_write(8'h94, 32'h0);
        bus_write(8'h98, 32'h0000_0020);
        check_pins("R2");
        bus_write(8'h98, 32'h0);
        check_pins("R3");

        // R4 reserved code changes nothing
        bus_write(8'h94, 32'h3);
        bus_write(8'h98, 32'hFFFF_FFFF);
        check_pins("R4");
        bus_write(8'h9C, 32'hFFFF_FFFF);
        check_pins("R4");
        bus_read(8'h94, 32'h3, "R1");

        // R10 back-to-back mode then strobe uses the new code
        bus_write(8'h94, 32'h2);
        bus_write(8'h9C, 32'h0000_0002);
        check_pins("R10");
        bus_write(8'h94, 32'h1);
        bus_write(8'h98, 32'h0000_0001);
        check_pins("R10");

        // R10 unmapped write ignored
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_write(8'h90, 32'h0000_0002);
        check_pins("R10");
        bus_read(8'h94, 32'h1, "R10");

        // R7 strobe and unmapped reads return zero
        bus_read(8'h98, 32'h0, "R7");
        bus_read(8'h9C, 32'h0, "R7");
        bus_read(8'h40, 32'h0, "R7");

        // R5 opposite pulls on neighbouring pins
        bus_write(8'h98, 32'hAAAA_AAAA);
        bus_write(8'h94, 32'h2);
        bus_write(8'h98, 32'h5555_5555);
        check_pins("R5");
        checks++;
        if ((pull_up_en & pull_dn_en) != '0) begin
            failures++;
            $display("FAIL R5 overlap: actual=%h expected=0", pull_up_en & pull_dn_en);
        end

        repeat (2) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R7 missing read data: actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule